// File: doc/BRIEF.md
# Ethernet Transmit Frame Sequencer

This block sits between a byte-wide transmit FIFO and a byte-wide media-independent transmit interface (`txd`, `tx_en`). When a start is allowed, it opens a frame and sends a fixed preamble and then a start-of-frame delimiter. It then moves the frame's bytes out of the FIFO at one byte per clock. It can close the frame with a 32-bit frame check sequence that it computes as the bytes pass through.

A frame may begin in two cases. In the first, the FIFO reports that a complete frame is buffered. In the second, the FIFO fill level has reached a programmable threshold, so a long frame can begin before its tail arrives. A gate input from the deferral and pause logic must be high for a frame to open. Once the frame is open, the gate is no longer consulted. An abort input ends the frame at once. A collision detected elsewhere is reported through the same input. If the FIFO runs dry while a payload byte is due, the frame is aborted in the same way. After any abort, the rest of the cut frame is read out of the FIFO and thrown away, so that the next frame starts cleanly.

Top module: `eth_tx_framer`

## Requirements
- R1: A frame opens only when `start_ok` is high, the FIFO is not empty, and either `frame_ready` is high or `fifo_level >= thresh`. `tx_en` rises on the clock after the cycle in which these conditions hold. Below the threshold and with no complete frame buffered, `tx_en` stays low.
- R2: Each frame begins with 7 cycles of `txd = 0x55`, followed by one cycle of `txd = 0xD5`, with `tx_en` high throughout.
- R3: After the delimiter, the frame bytes appear on `txd` in FIFO order, one per cycle. Each byte is popped with `fifo_pop` in the cycle before it is shown. The byte popped with `fifo_last = 1` is the final payload byte.
- R4: The two flags `crc_pad_flag` and `crc_app_flag` are sampled in the cycle the frame opens. If either flag is set, four check bytes follow the payload. These bytes are the complement of the reflected CRC-32 (polynomial 0xEDB88320, initial value 0xFFFFFFFF) over the payload, sent least-significant byte first. For the nine ASCII bytes "123456789", the check bytes are 26 39 F4 CB.
- R5: When both flags were clear at the start of the frame, no check bytes are sent. The frame ends right after the final payload byte.
- R6: `tx_en` falls on the cycle after the last byte of the frame. In that same cycle, `done` is high for exactly one cycle. Whenever `tx_en` is low, `txd` is 0.
- R7: Once a frame has opened, changes on `start_ok` have no effect. The frame completes normally.
- R8: An `abort_req` that is high during a frame drops `tx_en` and sets `txd` to 0 on the next clock, and pulses `aborted` for one cycle. `done` is not raised for that frame. An `abort_req` while idle has no effect.
- R9: If the FIFO is empty when a payload byte is due, the frame is aborted as in R8 (FIFO underflow). No pop is ever issued to an empty FIFO.
- R10: After an abort, the remaining bytes of the cut frame are popped and discarded while `tx_en` stays low. Discarding stops after the byte marked `fifo_last`. If that byte had already been sent, nothing is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_ok | input | 1 | Start gate from deferral/pause logic |
| thresh | input | LVL_W | Fill level at which a partial frame may start |
| fifo_data | input | 8 | Head byte of the FIFO (first-word fall-through) |
| fifo_last | input | 1 | Head byte is the last byte of its frame |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_level | input | LVL_W | Bytes held in the FIFO |
| frame_ready | input | 1 | At least one complete frame is buffered |
| fifo_pop | output | 1 | Consume the head byte at this clock |
| crc_pad_flag | input | 1 | Per-frame flag requesting check bytes |
| crc_app_flag | input | 1 | Per-frame flag requesting check bytes |
| abort_req | input | 1 | Terminate the current frame (abort or collision) |
| txd | output | 8 | Transmit byte |
| tx_en | output | 1 | Transmit enable |
| done | output | 1 | One-cycle pulse: frame completed |
| aborted | output | 1 | One-cycle pulse: frame cut short |

## Verification
The hardest situations to reach from the ports are those that depend on the FIFO and the frame being out of step. One is a threshold-started frame whose tail never arrives, which forces an underflow. The other is the cleanup that follows that underflow. The bench reaches both by loading fewer bytes than the frame holds, with no last marker, and a threshold equal to that count. It then holds the FIFO back until the underflow abort appears, and afterwards feeds the tail to confirm that it is discarded without raising `tx_en`. A mid-payload abort is timed from the count of bytes seen on `txd`, and a known-value check guards the byte order of the check sequence.

// File: rtl/txf_pkg.sv
package txf_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_PRE,
      S_SFD,
      S_DATA,
      S_FCS,
      S_DRAIN
   } txf_state_e;

   // One byte of the reflected CRC-32 (poly 0xEDB88320), LSB of the byte first
   function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c ^ {24'd0, d};
      for (int i = 0; i < 8; i++) begin
         r = r[0] ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
      end
      return r;
   endfunction

endpackage

// File: rtl/txf_start_ctl.sv
module txf_start_ctl #(
   parameter int LVL_W     = 8,
   parameter bit THRESH_EN = 1'b1
) (
   input  logic             start_ok,
   input  logic             fifo_empty,
   input  logic             frame_ready,
   input  logic [LVL_W-1:0] fifo_level,
   input  logic [LVL_W-1:0] thresh,
   output logic             go
);

   logic enough;

   generate
      if (THRESH_EN) begin : g_thresh
         assign enough = frame_ready || (fifo_level >= thresh);
      end else begin : g_whole
         logic unused_lvl;
         assign unused_lvl = ^{fifo_level, thresh};
         assign enough = frame_ready;
      end
   endgenerate

   assign go = start_ok && !fifo_empty && enough;

endmodule

// File: rtl/txf_crc32.sv
module txf_crc32 #(
   parameter bit GEN_FCS = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clear,
   input  logic        step,
   input  logic [7:0]  din,
   output logic [31:0] fcs
);
   import txf_pkg::*;

   generate
      if (GEN_FCS) begin : g_crc
         logic [31:0] crc_q;
         always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
               crc_q <= 32'hFFFF_FFFF;
            end else if (step) begin
               crc_q <= crc32_step(crc_q, din);
            end
         end
         assign fcs = ~crc_q;
      end else begin : g_nocrc
         logic unused_in;
         assign unused_in = ^{clk, rst_n, clear, step, din};
         assign fcs = 32'd0;
      end
   endgenerate

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer #(
   parameter int         LVL_W     = 8,
   parameter int         PRE_LEN   = 7,
   parameter logic [7:0] PRE_BYTE  = 8'h55,
   parameter logic [7:0] SFD_BYTE  = 8'hD5,
   parameter bit         THRESH_EN = 1'b1,
   parameter bit         GEN_FCS   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_ok,
   input  logic [LVL_W-1:0] thresh,
   input  logic [7:0]       fifo_data,
   input  logic             fifo_last,
   input  logic             fifo_empty,
   input  logic [LVL_W-1:0] fifo_level,
   input  logic             frame_ready,
   output logic             fifo_pop,
   input  logic             crc_pad_flag,
   input  logic             crc_app_flag,
   input  logic             abort_req,
   output logic [7:0]       txd,
   output logic             tx_en,
   output logic             done,
   output logic             aborted
);
   import txf_pkg::*;

   localparam int PRE_CW = $clog2(PRE_LEN + 1);
   localparam int CNT_W  = (PRE_CW > 3) ? PRE_CW : 3;
   localparam int FCS_N  = 4;

   if (PRE_LEN < 1) begin : g_bad_pre
      $error("PRE_LEN must be at least 1");
   end
   if (LVL_W < 1) begin : g_bad_lvl
      $error("LVL_W must be at least 1");
   end

   txf_state_e       st;
   logic [CNT_W-1:0] cnt;
   logic             fcs_q;
   logic             last_q;
   logic             go;
   logic             want_data;
   logic             take;
   logic             underflow;
   logic             in_frame;
   logic [31:0]      fcs;
   logic [7:0]       fcs_byte;

   txf_start_ctl #(.LVL_W(LVL_W), .THRESH_EN(THRESH_EN)) u_start (
      .start_ok    (start_ok),
      .fifo_empty  (fifo_empty),
      .frame_ready (frame_ready),
      .fifo_level  (fifo_level),
      .thresh      (thresh),
      .go          (go)
   );

   // a payload byte is due at the next edge
   assign want_data = (st == S_SFD) || ((st == S_DATA) && !last_q);
   assign in_frame  = (st != S_IDLE) && (st != S_DRAIN);
   assign take      = want_data && !abort_req && !fifo_empty;
   assign underflow = want_data && !abort_req && fifo_empty;
   assign fifo_pop  = take || ((st == S_DRAIN) && !fifo_empty);

   txf_crc32 #(.GEN_FCS(GEN_FCS)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clear ((st == S_IDLE) && go),
      .step  (take),
      .din   (fifo_data),
      .fcs   (fcs)
   );

   assign fcs_byte = fcs[{cnt[1:0], 3'b000} +: 8];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         cnt     <= '0;
         fcs_q   <= 1'b0;
         last_q  <= 1'b0;
         txd     <= 8'd0;
         tx_en   <= 1'b0;
         done    <= 1'b0;
         aborted <= 1'b0;
      end else begin
         done    <= 1'b0;
         aborted <= 1'b0;
         if (in_frame && (abort_req || underflow)) begin
            tx_en   <= 1'b0;
            txd     <= 8'd0;
            aborted <= 1'b1;
            st      <= last_q ? S_IDLE : S_DRAIN;
         end else begin
            case (st)
               S_IDLE: begin
                  if (go) begin
                     st     <= S_PRE;
                     tx_en  <= 1'b1;
                     txd    <= PRE_BYTE;
                     cnt    <= CNT_W'(1);
                     fcs_q  <= GEN_FCS && (crc_pad_flag || crc_app_flag);
                     last_q <= 1'b0;
                  end
               end
               S_PRE: begin
                  if (cnt == CNT_W'(PRE_LEN)) begin
                     txd <= SFD_BYTE;
                     st  <= S_SFD;
                  end else begin
                     txd <= PRE_BYTE;
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               S_SFD, S_DATA: begin
                  if (take) begin
                     txd    <= fifo_data;
                     last_q <= fifo_last;
                     st     <= S_DATA;
                  end else if (fcs_q) begin
                     txd <= fcs[7:0];
                     cnt <= CNT_W'(1);
                     st  <= S_FCS;
                  end else begin
                     txd   <= 8'd0;
                     tx_en <= 1'b0;
                     done  <= 1'b1;
                     st    <= S_IDLE;
                  end
               end
               S_FCS: begin
                  if (cnt == CNT_W'(FCS_N)) begin
                     txd   <= 8'd0;
                     tx_en <= 1'b0;
                     done  <= 1'b1;
                     st    <= S_IDLE;
                  end else begin
                     txd <= fcs_byte;
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               S_DRAIN: begin
                  if (!fifo_empty && fifo_last) begin
                     st <= S_IDLE;
                  end
               end
               default: st <= S_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/txf_checker.sv
module txf_checker #(
   parameter logic [7:0] PRE_BYTE = 8'h55
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start_ok,
   input logic       fifo_empty,
   input logic       fifo_pop,
   input logic [7:0] txd,
   input logic       tx_en,
   input logic       done,
   input logic       aborted
);

   // R1
   gate_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_en) |-> $past(start_ok));

   // R2
   first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_en) |-> (txd == PRE_BYTE));

   // R6
   done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!tx_en && $past(tx_en)));

   // R6
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |-> (txd == 8'd0));

   // R8
   end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && aborted));

   // R8
   abort_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      aborted |-> (!tx_en && $past(tx_en)));

   // R9
   no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> !fifo_empty);

endmodule

bind eth_tx_framer txf_checker #(.PRE_BYTE(PRE_BYTE)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_ok   (start_ok),
   .fifo_empty (fifo_empty),
   .fifo_pop   (fifo_pop),
   .txd        (txd),
   .tx_en      (tx_en),
   .done       (done),
   .aborted    (aborted)
);

// File: tb/sim_eth_tx_framer.sv
`timescale 1ns/1ps
module sim_eth_tx_framer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_ok = 1'b0;
   logic [7:0] thresh = 8'hFF;
   logic [7:0] fifo_data = 8'd0;
   logic       fifo_last = 1'b0;
   logic       fifo_empty = 1'b1;
   logic [7:0] fifo_level = 8'd0;
   logic       frame_ready = 1'b0;
   logic       fifo_pop;
   logic       crc_pad_flag = 1'b0;
   logic       crc_app_flag = 1'b0;
   logic       abort_req = 1'b0;
   logic [7:0] txd;
   logic       tx_en;
   logic       done;
   logic       aborted;

   always #2.5 clk = ~clk;

   eth_tx_framer u0 (
      .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .thresh(thresh),
      .fifo_data(fifo_data), .fifo_last(fifo_last), .fifo_empty(fifo_empty),
      .fifo_level(fifo_level), .frame_ready(frame_ready), .fifo_pop(fifo_pop),
      .crc_pad_flag(crc_pad_flag), .crc_app_flag(crc_app_flag),
      .abort_req(abort_req), .txd(txd), .tx_en(tx_en), .done(done),
      .aborted(aborted)
   );

   int errors = 0;
   int checks = 0;
   int cyc = 0;

   logic [7:0] qd[$];
   bit         ql[$];
   logic [7:0] cap[$];
   logic [7:0] pay[$];
   logic [7:0] expq[$];
   int         n_done = 0;
   int         n_abt = 0;

   task automatic refresh();
      bit any;
      any = 1'b0;
      foreach (ql[i]) if (ql[i]) any = 1'b1;
      fifo_empty  = (qd.size() == 0);
      fifo_data   = fifo_empty ? 8'd0 : qd[0];
      fifo_last   = fifo_empty ? 1'b0 : ql[0];
      fifo_level  = 8'(qd.size());
      frame_ready = any;
   endtask

   // FIFO model: consume after the edge at which the pop was requested
   always @(posedge clk) begin
      if (fifo_pop) begin
         #1;
         void'(qd.pop_front());
         void'(ql.pop_front());
         refresh();
      end
   end

   always @(negedge clk) begin
      if (tx_en) cap.push_back(txd);
      if (done) n_done++;
      if (aborted) n_abt++;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         errors++;
         $display("FAIL watchdog: act=%0d exp<%0d cycles", cyc, 150000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic chk(bit ok, string rq, longint act, longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: act=%0h exp=%0h", rq, act, expv);
      end
   endtask

   function automatic logic [31:0] ref_crc();
      logic [31:0] c;
      c = 32'hFFFF_FFFF;
      foreach (pay[i]) begin
         c = c ^ {24'd0, pay[i]};
         for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
      end
      return ~c;
   endfunction

   task automatic push_pay(int from, int upto, bit mark_last);
      for (int i = from; i < upto; i++) begin
         qd.push_back(pay[i]);
         ql.push_back(mark_last && (i == upto - 1));
      end
      refresh();
   endtask

   task automatic clear_obs();
      cap.delete();
      n_done = 0;
      n_abt = 0;
   endtask

   task automatic wait_end(int limit);
      for (int i = 0; i < limit; i++) begin
         @(negedge clk); #1;
         if (n_done + n_abt > 0) break;
      end
      repeat (2) @(negedge clk);
      #1;
   endtask

   task automatic build_exp(bit with_fcs, int npay);
      logic [31:0] f;
      expq.delete();
      for (int i = 0; i < 7; i++) expq.push_back(8'h55);
      expq.push_back(8'hD5);
      for (int i = 0; i < npay; i++) expq.push_back(pay[i]);
      if (with_fcs) begin
         f = ref_crc();
         for (int i = 0; i < 4; i++) expq.push_back(f[8*i +: 8]);
      end
   endtask

   task automatic cmp_cap(string rq);
      int bad;
      int first;
      bad = 0;
      first = -1;
      chk(cap.size() == expq.size(), rq, cap.size(), expq.size());
      for (int i = 0; i < cap.size() && i < expq.size(); i++) begin
         if (cap[i] !== expq[i]) begin
            bad++;
            if (first < 0) first = i;
         end
      end
      if (first >= 0) chk(1'b0, rq, cap[first], expq[first]);
      else chk(1'b1, rq, 0, 0);
   endtask

   task automatic make_pay(int len);
      pay.delete();
      for (int i = 0; i < len; i++) pay.push_back(8'($urandom));
   endtask

   task automatic full_frame(int len, bit pf, bit af, string rq);
      make_pay(len);
      crc_pad_flag = pf;
      crc_app_flag = af;
      clear_obs();
      push_pay(0, len, 1'b1);
      wait_end(400);
      build_exp(pf || af, len);
      cmp_cap(rq);
      chk(n_done == 1 && n_abt == 0, {rq, " done pulse"}, n_done, 1);
      chk(tx_en == 1'b0 && txd == 8'd0, "R6 idle after frame", {tx_en, txd}, 0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      refresh();
      repeat (4) @(negedge clk);
      // R6 reset state
      chk(tx_en == 0 && txd == 0 && done == 0 && aborted == 0 && fifo_pop == 0,
          "R6 reset outputs", {tx_en, txd, done, aborted, fifo_pop}, 0);
      rst_n = 1'b1;
      start_ok = 1'b1;
      @(negedge clk);

      // R5 / R4 flag combinations on short frames
      full_frame(1, 0, 0, "R5 no fcs len1");
      full_frame(1, 1, 0, "R4 pad flag");
      full_frame(5, 0, 1, "R4 app flag");
      full_frame(3, 1, 1, "R4 both flags");

      // R4 known value: "123456789"
      pay.delete();
      for (int i = 0; i < 9; i++) pay.push_back(8'(8'h31 + i));
      crc_pad_flag = 1; crc_app_flag = 0;
      clear_obs();
      push_pay(0, 9, 1'b1);
      wait_end(200);
      chk(cap.size() == 21, "R4 known length", cap.size(), 21);
      if (cap.size() == 21)
         chk({cap[20], cap[19], cap[18], cap[17]} == 32'hCBF43926, "R4 known fcs",
             {cap[20], cap[19], cap[18], cap[17]}, 32'hCBF43926);
      chk(cap.size() > 9 && cap[8] == 8'h31, "R3 first payload byte", cap.size() > 9 ? cap[8] : 0, 8'h31);

      // R1 gate low blocks start
      start_ok = 1'b0;
      make_pay(6);
      crc_pad_flag = 0; crc_app_flag = 0;
      clear_obs();
      push_pay(0, 6, 1'b1);
      repeat (30) @(negedge clk);
      #1;
      chk(cap.size() == 0, "R1 gate low holds", cap.size(), 0);
      start_ok = 1'b1;
      wait_end(200);
      build_exp(0, 6);
      cmp_cap("R1 start after gate");

      // R1 threshold start with a partial frame
      thresh = 8'd4;
      make_pay(10);
      clear_obs();
      push_pay(0, 2, 1'b0);
      repeat (30) @(negedge clk);
      #1;
      chk(cap.size() == 0, "R1 below threshold", cap.size(), 0);
      push_pay(2, 4, 1'b0);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk); #1;
         if (tx_en) break;
      end
      chk(tx_en == 1'b1, "R1 threshold start", tx_en, 1);
      push_pay(4, 10, 1'b1);
      wait_end(200);
      build_exp(0, 10);
      cmp_cap("R1 R3 threshold frame");
      chk(n_done == 1, "R6 threshold done", n_done, 1);
      thresh = 8'hFF;

      // R7 gate dropped after start
      make_pay(30);
      crc_app_flag = 1;
      clear_obs();
      push_pay(0, 30, 1'b1);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk); #1;
         if (tx_en) break;
      end
      start_ok = 1'b0;
      wait_end(200);
      build_exp(1, 30);
      cmp_cap("R7 gate ignored");
      start_ok = 1'b1;
      crc_app_flag = 0;

      // R8 abort in idle has no effect
      clear_obs();
      abort_req = 1'b1;
      @(negedge clk);
      abort_req = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk(n_abt == 0 && tx_en == 0, "R8 idle abort ignored", n_abt, 0);

      // R8 / R10 abort mid-payload, then drain
      make_pay(20);
      crc_pad_flag = 1;
      clear_obs();
      push_pay(0, 20, 1'b1);
      for (int i = 0; i < 100; i++) begin
         @(negedge clk); #1;
         if (cap.size() == 13) break;
      end
      abort_req = 1'b1;
      @(negedge clk);
      abort_req = 1'b0;
      #1;
      chk(tx_en == 1'b0 && aborted == 1'b1, "R8 abort next cycle", {tx_en, aborted}, 2'b01);
      repeat (30) @(negedge clk);
      #1;
      chk(cap.size() == 13 && n_done == 0, "R8 no more bytes, no done", cap.size(), 13);
      chk(qd.size() == 0, "R10 rest discarded", qd.size(), 0);
      crc_pad_flag = 0;
      full_frame(4, 0, 1, "R10 recovery frame");

      // R9 underflow on a threshold-started frame, R10 drain of the tail
      thresh = 8'd3;
      make_pay(7);
      clear_obs();
      push_pay(0, 3, 1'b0);
      wait_end(200);
      build_exp(0, 3);
      cmp_cap("R9 underflow bytes");
      chk(n_abt == 1 && n_done == 0, "R9 underflow aborts", n_abt, 1);
      thresh = 8'hFF;
      clear_obs();
      push_pay(3, 7, 1'b1);
      repeat (15) @(negedge clk);
      #1;
      chk(qd.size() == 0 && cap.size() == 0, "R10 tail drained silently", qd.size() + cap.size(), 0);

      // random frames
      for (int k = 0; k < 25; k++) begin
         full_frame(1 + int'($urandom % 48), 1'($urandom), 1'($urandom), "R2 R3 R4 random");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule